// File: doc/BRIEF.md
# Byte-Stepped I2C Bus Master

This block is a single-master I2C controller that software runs one byte at a time through four byte-wide registers: control, status/mode, own address and data shift. A write to the status register with a master mode, the enable bit and the start bit set issues a START condition. The data register is then sent as the address byte, which is the 7-bit target address shifted left by one with R/W in bit 0. After that the block moves one data byte per step, out or in according to the mode bits. Every completed byte, including its acknowledge bit, sets an interrupt-pending flag. The clock line then stays low and the bus does nothing more until software writes that flag to zero.

STOP and repeated START are requested by writing the status register while a byte is pending. The request takes effect when the flag is cleared. In receive mode, the acknowledge-generation bit in the control register sets the level the master drives after each incoming byte. Software clears it before the final byte so that the byte ends with a NACK. The bit clock is the system clock divided by a selectable prescaler of 16 or 512 and then by (divisor + 1). The block drives open-drain style outputs, where 1 means released and 0 means pulled low, and it reads the resolved data line back.

Top module: `i2c_byte_master`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0: control, status (mode 00 = slave receive, not busy) and data. Both bus outputs are released (1) and irq is 0.
- R2: One SCL period is P*(D+1) system clocks. P is 16 when control bit 6 is 0 and 512 when it is 1. D is control bits [3:0].
- R3: A status write with bit 7 = 1, bit 5 = 1 and bit 4 = 1 issued while idle produces a START. SDA falls while SCL is high. The data register is then sent as the address byte. Status bit 5 reads 1 from the START until the STOP completes.
- R4: Transmitted bytes go out MSB first. SDA changes only while SCL is low. The acknowledge bit sampled after an address byte or a transmitted byte appears in status bit 0, where 0 means acknowledged and 1 means not acknowledged.
- R5: After the ninth clock of every byte, control bit 4 (pending) reads 1. The irq output equals pending AND control bit 5 (interrupt enable).
- R6: While pending is 1, SCL is held low and no transfer proceeds. Writing control bit 4 as 1 leaves pending set. Only writing it as 0 releases the next step.
- R7: With mode bits [7:6] = 10 (master receive), clearing pending clocks in one byte, MSB first, and it reads back from the data register. After that byte the master drives SDA low as the acknowledge bit when control bit 7 is 1, and releases it (NACK) when control bit 7 is 0.
- R8: A status write with bit 4 = 1 and bit 5 = 0 while a byte is pending, followed by clearing pending, produces a STOP. SDA rises while SCL is high, both lines are then released, and status bit 5 reads 0.
- R9: A START command (as in R3) written while a byte is pending, followed by clearing pending, produces a repeated START without an intervening STOP. The data register is then sent as the new address byte, and later bytes follow the newly written mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status/mode, 2 own address, 3 data shift |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Byte-complete interrupt request |
| scl_o | output | 1 | Clock line drive, 1 = released, 0 = pulled low |
| sda_o | output | 1 | Data line drive, 1 = released, 0 = pulled low |
| sda_i | input | 1 | Resolved level of the data line |

## Verification
The hardest case to reach is the repeated START. It requires a START command to be latched while the clock is parked low under a pending byte, and the command then has to act on the flag release instead of on the write itself. The stimulus reaches it with a write byte that is followed by a read address byte in the same transaction. A bus-level target model counts STARTs and STOPs, acknowledges only its own address, serves read data and checks every byte and master acknowledge against a queue that the driver fills. The stalled clock is observed over hundreds of cycles under a pending flag, and a write of 1 to that flag is also made during the stall.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512,
  parameter int DIV_W  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i
);

  localparam int CW = $clog2((PRE_HI / 4) * (1 << DIV_W)) + 1;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_OWN = 2'd2, A_SHIFT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_HOLD, S_STOP} st_t;

  st_t             st;
  logic [DIV_W-1:0] div;
  logic            pend, ie, psel, ackgen, en, ackrx;
  logic [1:0]      mode;
  logic [7:0]      own, shreg;
  logic [1:0]      q;
  logic [3:0]      bitn;
  logic            rx, samp, start_req, stop_req;
  logic [CW-1:0]   cnt, lim;
  logic            tick, busy;

  wire wr_ctrl   = reg_we && reg_addr == A_CTRL;
  wire wr_stat   = reg_we && reg_addr == A_STAT;
  wire wr_own    = reg_we && reg_addr == A_OWN;
  wire wr_shift  = reg_we && reg_addr == A_SHIFT;
  wire cmd_start = wr_stat && reg_wdata[7] && reg_wdata[5] && reg_wdata[4];
  wire cmd_stop  = wr_stat && !reg_wdata[5] && reg_wdata[4];
  wire release_p = wr_ctrl && !reg_wdata[4] && pend;

  assign lim  = CW'((psel ? PRE_HI / 4 : PRE_LO / 4) * (int'(div) + 1) - 1);
  assign tick = (st != S_IDLE) && (st != S_HOLD) && (cnt == lim);
  assign busy = (st != S_IDLE);
  assign irq  = pend & ie;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {ackgen, psel, ie, pend, 4'(div)};
      A_STAT:  reg_rdata = {mode, busy, en, 3'b000, ackrx};
      A_OWN:   reg_rdata = own;
      default: reg_rdata = shreg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; pend <= 1'b0; ie <= 1'b0; psel <= 1'b0;
      ackgen <= 1'b0; en <= 1'b0; ackrx <= 1'b0; mode <= 2'b00;
      own <= '0; shreg <= '0; q <= '0; bitn <= '0; rx <= 1'b0;
      samp <= 1'b0; start_req <= 1'b0; stop_req <= 1'b0; cnt <= '0;
    end else begin
      if (wr_ctrl) begin
        div    <= DIV_W'(reg_wdata[3:0]);
        ie     <= reg_wdata[5];
        psel   <= reg_wdata[6];
        ackgen <= reg_wdata[7];
        if (!reg_wdata[4]) pend <= 1'b0;
      end
      if (wr_stat) begin
        mode <= reg_wdata[7:6];
        en   <= reg_wdata[4];
      end
      if (wr_own) own <= reg_wdata;
      if (wr_shift && st != S_BIT) shreg <= reg_wdata;
      cnt <= (tick || st == S_IDLE || st == S_HOLD) ? '0 : cnt + 1'b1;
      if (tick) q <= q + 2'd1;
      case (st)
        S_IDLE: if (cmd_start) begin
          st <= S_START;
          q  <= '0;
        end
        S_START: if (tick && q == 2'd3) begin
          st   <= S_BIT;
          rx   <= 1'b0;
          bitn <= '0;
        end
        S_BIT: if (tick) begin
          if (q == 2'd2) samp <= sda_i;
          if (q == 2'd3) begin
            if (bitn == 4'd8) begin
              st   <= S_HOLD;
              pend <= 1'b1;
              if (!rx) ackrx <= samp;
            end else begin
              shreg <= {shreg[6:0], rx ? samp : shreg[7]};
              bitn  <= bitn + 4'd1;
            end
          end
        end
        S_HOLD: begin
          if (cmd_start) start_req <= 1'b1;
          if (cmd_stop)  stop_req  <= 1'b1;
          if (release_p) begin
            start_req <= 1'b0;
            stop_req  <= 1'b0;
            q         <= '0;
            if (stop_req)       st <= S_STOP;
            else if (start_req) st <= S_START;
            else begin
              st   <= S_BIT;
              rx   <= !mode[0];
              bitn <= '0;
            end
          end
        end
        S_STOP: if (tick && q == 2'd3) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_START: begin scl_o = (q == 2'd1) || (q == 2'd2); sda_o = !q[1]; end
      S_BIT: begin
        scl_o = q[1];
        if (bitn == 4'd8) sda_o = rx ? !ackgen : 1'b1;
        else              sda_o = rx ? 1'b1 : shreg[7];
      end
      S_HOLD:  begin scl_o = 1'b0; sda_o = 1'b1; end
      S_STOP:  begin scl_o = (q != 2'd0); sda_o = (q == 2'd3); end
      default: begin scl_o = 1'b1; sda_o = 1'b1; end
    endcase
  end

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && scl_o && $past(st == S_BIT && scl_o)) |-> $stable(sda_o)); // R4
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT) |-> (bitn <= 4'd8)); // R4
  AST_PEND_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(st == S_BIT)); // R5
  AST_PEND_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !scl_o); // R6
  AST_HOLD_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == S_HOLD) && st != S_HOLD) |-> $past(release_p)); // R6
  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !pend); // R8

endmodule

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_o, sda_o;
  logic drv = 1'b0;
  wire  sda_line = sda_o & ~drv;

  always #2.5 clk = ~clk;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_line));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_wr[$];
  logic       exp_mack[$];
  logic [7:0] slv_tx[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target model and scoreboard monitor
  int bitn = -1, starts = 0, stops = 0;
  logic rd = 0, adph = 0, ackok = 0, mack = 0;
  logic [7:0] sr = '0, cur = '0;

  always @(negedge sda_line) begin
    #1;
    if (scl_o && !sda_line) begin starts++; bitn = -1; adph = 1; drv = 0; end
  end
  always @(posedge sda_line) begin
    #1;
    if (scl_o && sda_line) begin stops++; bitn = -1; drv = 0; end
  end
  always @(posedge scl_o) begin
    if (bitn >= 0 && bitn < 8) sr = {sr[6:0], sda_line};
    else if (bitn == 8 && rd && !adph && ackok) begin
      mack = sda_line;
      if (exp_mack.size() == 0) chk("R7 unexpected master ack", 1, 0);
      else chk("R7 master ack level", int'(mack), int'(exp_mack.pop_front()));
    end
  end
  always @(negedge scl_o) begin
    if (bitn < 0) bitn = 0;
    else if (bitn < 7) begin
      if (rd && !adph && ackok) drv = ~cur[6-bitn];
      bitn++;
    end else if (bitn == 7) begin
      if (rd && !adph && ackok) drv = 0;
      else begin
        if (exp_wr.size() == 0) chk("R4 unexpected bus byte", int'(sr), -1);
        else chk("R4 byte seen on bus", int'(sr), int'(exp_wr.pop_front()));
        if (adph) begin rd = sr[0]; ackok = (sr[7:1] == 7'h50); end
        drv = ackok;
      end
      bitn = 8;
    end else begin
      drv = 0;
      if (ackok && rd && (adph || !mack) && slv_tx.size() > 0) begin
        cur = slv_tx.pop_front();
        drv = ~cur[7];
      end
      adph = 0; mack = 0; bitn = 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rdr(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic wait_pend(input string tag);
    logic [7:0] v;
    v = 0;
    for (int i = 0; i < 40000; i++) begin rdr(2'd0, v); if (v[4]) break; end
    chk(tag, int'(v[4]), 1);
  endtask
  task automatic wait_idle(input string tag);
    logic [7:0] v;
    v = 8'hff;
    for (int i = 0; i < 40000; i++) begin rdr(2'd1, v); if (!v[5]) break; end
    chk(tag, int'(v[5]), 0);
  endtask
  task automatic send_addr(input logic [7:0] ab, input logic [7:0] stat);
    wr(2'd3, ab); exp_wr.push_back(ab); wr(2'd1, stat);
  endtask

  initial begin
    logic [7:0] v;
    int st0, sp0;
    realtime t0, t1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rdr(2'd0, v); chk("R1 control after reset", v, 0);
    rdr(2'd1, v); chk("R1 status after reset", v, 0);
    rdr(2'd3, v); chk("R1 data after reset", v, 0);
    chk("R1 bus released", int'({scl_o, sda_o, irq}), 3'b110);

    // write transaction, R3 R4 R5 R6 R8
    wr(2'd0, 8'hA0);
    st0 = starts;
    send_addr(8'hA0, 8'hF0);
    wait_pend("R5 pending after address");
    chk("R3 one START seen", starts - st0, 1);
    rdr(2'd1, v); chk("R4 address acked", v[0], 0); chk("R3 busy during transfer", v[5], 1);
    chk("R5 irq with enable", irq, 1);
    v = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (scl_o) v = 1; end
    chk("R6 SCL held low while pending", v, 0);
    wr(2'd0, 8'hB0);
    repeat (100) @(negedge clk);
    rdr(2'd0, v); chk("R6 writing 1 keeps pending", v[4], 1);
    chk("R6 SCL still low", scl_o, 0);
    wr(2'd3, 8'h3C); exp_wr.push_back(8'h3C); wr(2'd0, 8'hA0);
    rdr(2'd0, v); chk("R6 pending cleared by 0", v[4], 0);
    wait_pend("R5 pending after data byte");
    wr(2'd3, 8'hA5); exp_wr.push_back(8'hA5); wr(2'd0, 8'hA0);
    wait_pend("R5 pending after second byte");
    rdr(2'd1, v); chk("R4 data acked", v[0], 0);
    sp0 = stops;
    wr(2'd1, 8'hD0); wr(2'd0, 8'hA0);
    wait_idle("R8 busy clears after STOP");
    chk("R8 one STOP seen", stops - sp0, 1);
    chk("R8 bus released", int'({scl_o, sda_o}), 2'b11);

    // NACK on foreign address, R4
    send_addr(8'h66, 8'hF0);
    wait_pend("R5 pending after nacked address");
    rdr(2'd1, v); chk("R4 nack reported", v[0], 1);
    wr(2'd1, 8'hD0); wr(2'd0, 8'hA0);
    wait_idle("R8 STOP after nack");

    // receive with interrupts disabled, R5 R7
    wr(2'd0, 8'h80);
    slv_tx.push_back(8'h5A); slv_tx.push_back(8'hC3);
    send_addr(8'hA1, 8'hB0);
    wait_pend("R5 pending after read address");
    chk("R5 irq masked", irq, 0);
    rdr(2'd1, v); chk("R4 read address acked", v[0], 0);
    exp_mack.push_back(1'b0); wr(2'd0, 8'h80);
    wait_pend("R7 pending after first read byte");
    rdr(2'd3, v); chk("R7 first byte received", v, 8'h5A);
    exp_mack.push_back(1'b1); wr(2'd0, 8'h00);
    wait_pend("R7 pending after last read byte");
    rdr(2'd3, v); chk("R7 last byte received", v, 8'hC3);
    wr(2'd1, 8'h90); wr(2'd0, 8'h00);
    wait_idle("R8 STOP after read");

    // repeated START, R9
    wr(2'd0, 8'hA0);
    st0 = starts; sp0 = stops;
    send_addr(8'hA0, 8'hF0);
    wait_pend("R9 pending after address");
    wr(2'd3, 8'h77); exp_wr.push_back(8'h77); wr(2'd0, 8'hA0);
    wait_pend("R9 pending after write byte");
    slv_tx.push_back(8'h96);
    send_addr(8'hA1, 8'hB0);
    rdr(2'd0, v); chk("R9 start waits for release", v[4], 1);
    wr(2'd0, 8'hA0);
    wait_pend("R9 pending after new address");
    chk("R9 two STARTs", starts - st0, 2);
    chk("R9 no STOP between", stops - sp0, 0);
    exp_mack.push_back(1'b1); wr(2'd0, 8'h20);
    wait_pend("R9 pending after read byte");
    rdr(2'd3, v); chk("R9 byte read after repeated START", v, 8'h96);
    wr(2'd1, 8'h90); wr(2'd0, 8'h20);
    wait_idle("R8 STOP after repeated START");

    // R2 clock period, two settings
    for (int k = 0; k < 2; k++) begin
      logic [7:0] cv;
      int expc;
      cv   = (k == 0) ? 8'h03 : 8'h41;
      expc = (k == 0) ? 16 * 4 : 512 * 2;
      wr(2'd0, cv);
      send_addr(8'hA0, 8'hF0);
      @(posedge scl_o); @(posedge scl_o); t0 = $realtime;
      @(posedge scl_o); t1 = $realtime;
      chk("R2 SCL period in clocks", int'((t1 - t0) / 5.0), expc);
      wait_pend("R2 pending after timed byte");
      wr(2'd1, 8'hD0); wr(2'd0, cv);
      wait_idle("R8 STOP after timed byte");
    end

    repeat (20) @(negedge clk);
    chk("R4 scoreboard bytes drained", exp_wr.size(), 0);
    chk("R7 scoreboard acks drained", exp_mack.size(), 0);
    chk("R7 target data drained", slv_tx.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule